// File: doc/BRIEF.md
# Tag-Broadcast Out-of-Order Scheduler for a Four-Register File

This block accepts one instruction per cycle, in program order, and lets those instructions finish out of order. It works on a file of four 32-bit architectural registers. Each register has a status entry. The entry is either zero, which means the register value is current, or the nonzero tag of the station that will produce the next value. Arithmetic goes to small pools of add and multiply stations. Each station holds its operands either as values or as the tags it is still waiting for. Loads go to memory buffers that model a slow memory with sixteen independent word banks. Stores wait in store buffers until their data is known.

Every finished result leaves on a single shared result bus, together with the tag of the station that made it. Any register status entry, station operand slot or store data slot that waits on that tag takes the value in the same cycle, whatever the number of waiters. The bus carries at most one result per cycle. A load to an address that still has a store pending does not read memory. It is renamed to the tag that the store's data is waiting on, so the value arrives over the result bus. The add and multiply units are integer placeholders with fixed latency.

The caller presents an instruction with `iss_valid` and holds it until `iss_ready` is high at a clock edge. The caller then watches the register outputs, or the result bus, to see the results.

Top module: `tsb_core`

## Requirements
- R1: A synchronous active-high reset sets register r to r+1 with every status entry ready. It sets memory word a to 100+a, frees every station, and drives `quiet` high and `iss_ready` high for an add.
- R2: The opcodes are encoded as follows. 0 is ADD (dst = src1 + src2, modulo 2^32). 1 is MUL (dst = low 32 bits of src1 * src2). 2 is LOAD (dst = mem[addr]). 3 is STORE (mem[addr] = src1). After any sequence has drained, the register file and memory equal an in-order execution of the same sequence.
- R3: The bus carries at most one result per cycle, and the tag it carries is never 0. With the default sizes the tags are fixed: add stations 1–2, multiply stations 3–4, load buffers 5–6, store buffers 7–8.
- R4: When more than one unit has a result ready, the bus takes multiply first, then add, then load. A unit that loses keeps its tag and value unchanged until it is granted.
- R5: A waiting register, operand slot or store data slot takes a bus value only when its tag matches the bus tag. One broadcast satisfies every waiter at once.
- R6: A broadcast clears a register status entry only if that entry still holds the broadcast tag. An older producer therefore never overwrites a later rename of the same register.
- R7: An instruction that issues in the same cycle as the broadcast of one of its source tags takes the broadcast value directly.
- R8: `iss_ready` is low when no station of the needed kind is free (two per kind by default). The other kinds are not affected.
- R9: When its operands are ready and the bus is free, an add result appears on the bus in the cycle after the ADD_LAT-th clock edge that follows the issue edge. A multiply result appears after MUL_LAT edges in the same way.
- R10: A load whose address matches a pending store takes that store's data tag or value. It allocates no load buffer, and no load tag (5 or 6) is ever broadcast for it.
- R11: A load with no matching pending store broadcasts its memory word, under its load-buffer tag, in the cycle after the MEM_LAT-th edge that follows its issue edge.
- R12: A store to an address that already has a pending store is held off (`iss_ready` low) until the earlier store has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Instruction present |
| iss_op | input | 2 | Opcode: 0 add, 1 mul, 2 load, 3 store |
| iss_dst | input | 2 | Destination register |
| iss_src1 | input | 2 | First source register (store data) |
| iss_src2 | input | 2 | Second source register |
| iss_addr | input | 4 | Memory word address for load and store |
| iss_ready | output | 1 | Instruction accepted at this edge if valid |
| regs_flat | output | 128 | Architectural registers, register r at bits r*32 +: 32 |
| quiet | output | 1 | No station busy and every register current |
| cdb_valid | output | 1 | Result bus carries a value this cycle |
| cdb_tag | output | 4 | Producer tag on the result bus |
| cdb_value | output | 32 | Value on the result bus |

## Verification
The embedded properties take some things for granted about the inputs. They assume that the issue fields stay stable while `iss_valid` waits for `iss_ready`, and that reset is held for at least one edge before any instruction is offered. The hold and priority properties also rely on the caller never forcing a result off the bus, since the only grant source is the internal arbiter. The bench drives every input at the falling edge and keeps each instruction on the port until an edge accepts it. It offers a stalled instruction for observation only, at that falling edge, before it either withdraws or completes it.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
    localparam int TAG_W  = 4;
    localparam int DATA_W = 32;
    localparam int NREG   = 4;
    localparam int REG_W  = 2;
    localparam int ADDR_W = 4;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_ADD   = 2'd0,
        OP_MUL   = 2'd1,
        OP_LOAD  = 2'd2,
        OP_STORE = 2'd3
    } op_e;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        word_t value;
    } bus_t;

    // operand slot: q == 0 means v holds the value
    typedef struct packed {
        tag_t  q;
        word_t v;
    } opnd_t;

    function automatic opnd_t snoop(input opnd_t o, input bus_t b);
        opnd_t r;
        r = o;
        if (o.q != '0 && b.valid && b.tag == o.q) begin
            r.q = '0;
            r.v = b.value;
        end
        return r;
    endfunction
endpackage

// File: rtl/tsb_rs_bank.sv
module tsb_rs_bank
    import tsb_pkg::*;
#(
    parameter int N    = 2,
    parameter int BASE = 1,
    parameter int LAT  = 2,
    parameter bit IS_MUL = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  bus_t  bus,
    input  logic  alloc,
    input  opnd_t a_in,
    input  opnd_t b_in,
    output logic  has_free,
    output tag_t  free_tag,
    output logic  req,
    output tag_t  req_tag,
    output word_t req_val,
    input  logic  grant,
    output logic  idle
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam int CW = $clog2(LAT + 1);

    logic [N-1:0]  busy, disp;
    opnd_t         opa [N];
    opnd_t         opb [N];
    logic          ubusy, rdy_any;
    logic [CW-1:0] ucnt;
    logic [IW-1:0] uidx, fidx, ridx;
    word_t         ures;

    always_comb begin
        has_free = 1'b0;
        fidx     = '0;
        rdy_any  = 1'b0;
        ridx     = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                has_free = 1'b1;
                fidx     = IW'(i);
            end
            if (busy[i] && !disp[i] && opa[i].q == '0 && opb[i].q == '0) begin
                rdy_any = 1'b1;
                ridx    = IW'(i);
            end
        end
    end

    assign free_tag = tag_t'(BASE) + tag_t'(fidx);
    assign req      = ubusy && (ucnt == '0);
    assign req_tag  = tag_t'(BASE) + tag_t'(uidx);
    assign req_val  = ures;
    assign idle     = ~|busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= '0;
            disp  <= '0;
            ubusy <= 1'b0;
            ucnt  <= '0;
            uidx  <= '0;
            ures  <= '0;
            for (int i = 0; i < N; i++) begin
                opa[i] <= '0;
                opb[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                opa[i] <= snoop(opa[i], bus);
                opb[i] <= snoop(opb[i], bus);
            end
            if (alloc) begin
                busy[fidx] <= 1'b1;
                disp[fidx] <= 1'b0;
                opa[fidx]  <= a_in;
                opb[fidx]  <= b_in;
            end
            if (!ubusy && rdy_any) begin
                ubusy      <= 1'b1;
                ucnt       <= CW'(LAT - 1);
                uidx       <= ridx;
                disp[ridx] <= 1'b1;
                ures       <= IS_MUL ? word_t'(opa[ridx].v * opb[ridx].v)
                                     : word_t'(opa[ridx].v + opb[ridx].v);
            end else if (ubusy && ucnt != '0) begin
                ucnt <= ucnt - CW'(1);
            end
            if (grant) begin
                ubusy      <= 1'b0;
                busy[uidx] <= 1'b0;
            end
        end
    end

    // R4: a result that lost arbitration stays put
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (req && !grant) |=> (req && $stable(req_tag) && $stable(req_val)));
    // R3: bus grant only reaches a unit holding a result
    assert_grant_req_R3: assert property (@(posedge clk) disable iff (rst)
        grant |-> req);
    // R8: allocation never lands on a full pool
    assert_alloc_free_R8: assert property (@(posedge clk) disable iff (rst)
        alloc |-> has_free);
endmodule

// File: rtl/tsb_ld_bank.sv
module tsb_ld_bank
    import tsb_pkg::*;
#(
    parameter int N    = 2,
    parameter int BASE = 5,
    parameter int LAT  = 12
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  alloc,
    input  word_t mem_data,
    output logic  has_free,
    output tag_t  free_tag,
    output logic  req,
    output tag_t  req_tag,
    output word_t req_val,
    input  logic  grant,
    output logic  idle
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam int CW = $clog2(LAT + 1);

    logic [N-1:0]  busy;
    logic [CW-1:0] cnt [N];
    word_t         data [N];
    logic [IW-1:0] fidx, gidx;

    always_comb begin
        has_free = 1'b0;
        fidx     = '0;
        req      = 1'b0;
        gidx     = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                has_free = 1'b1;
                fidx     = IW'(i);
            end
            if (busy[i] && cnt[i] == '0) begin
                req  = 1'b1;
                gidx = IW'(i);
            end
        end
    end

    assign free_tag = tag_t'(BASE) + tag_t'(fidx);
    assign req_tag  = tag_t'(BASE) + tag_t'(gidx);
    assign req_val  = data[gidx];
    assign idle     = ~|busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= '0;
            for (int i = 0; i < N; i++) begin
                cnt[i]  <= '0;
                data[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (busy[i] && cnt[i] != '0) cnt[i] <= cnt[i] - CW'(1);
            end
            if (alloc) begin
                busy[fidx] <= 1'b1;
                cnt[fidx]  <= CW'(LAT);
                data[fidx] <= mem_data;
            end
            if (grant) busy[gidx] <= 1'b0;
        end
    end

    // R4: a waiting memory result stays put
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (req && !grant) |=> (req && $stable(req_tag) && $stable(req_val)));
    // R8: allocation never lands on a full pool
    assert_alloc_free_R8: assert property (@(posedge clk) disable iff (rst)
        alloc |-> has_free);
endmodule

// File: rtl/tsb_st_bank.sv
module tsb_st_bank
    import tsb_pkg::*;
#(
    parameter int N    = 2,
    parameter int BASE = 7,
    parameter int AW   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_t          bus,
    input  logic          alloc,
    input  logic [AW-1:0] st_addr,
    input  opnd_t         d_in,
    output logic          has_free,
    output tag_t          free_tag,
    input  logic [AW-1:0] lk_addr,
    output logic          fwd_hit,
    output opnd_t         fwd,
    output word_t         rd_data,
    output logic          idle
);
    localparam int IW    = (N > 1) ? $clog2(N) : 1;
    localparam int DEPTH = 1 << AW;

    word_t         mem  [DEPTH];
    logic [N-1:0]  busy;
    logic [AW-1:0] addr [N];
    opnd_t         dat  [N];
    logic [IW-1:0] fidx;

    always_comb begin
        has_free = 1'b0;
        fidx     = '0;
        fwd_hit  = 1'b0;
        fwd      = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                has_free = 1'b1;
                fidx     = IW'(i);
            end
            if (busy[i] && addr[i] == lk_addr) begin
                fwd_hit = 1'b1;
                fwd     = dat[i];
            end
        end
    end

    assign free_tag = tag_t'(BASE) + tag_t'(fidx);
    assign rd_data  = mem[lk_addr];
    assign idle     = ~|busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= '0;
            for (int a = 0; a < DEPTH; a++) mem[a] <= word_t'(100 + a);
            for (int i = 0; i < N; i++) begin
                addr[i] <= '0;
                dat[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (busy[i] && dat[i].q == '0) begin
                    mem[addr[i]] <= dat[i].v;
                    busy[i]      <= 1'b0;
                end else begin
                    dat[i] <= snoop(dat[i], bus);
                end
            end
            if (alloc) begin
                busy[fidx] <= 1'b1;
                addr[fidx] <= st_addr;
                dat[fidx]  <= d_in;
            end
        end
    end

    // R12: at most one pending store per address
    for (genvar i = 0; i < N; i++) begin : g_pi
        for (genvar j = i + 1; j < N; j++) begin : g_pj
            assert_unique_addr_R12: assert property (@(posedge clk) disable iff (rst)
                (busy[i] && busy[j]) |-> (addr[i] != addr[j]));
        end
    end
endmodule

// File: rtl/tsb_core.sv
module tsb_core
    import tsb_pkg::*;
#(
    parameter int N_ADD   = 2,
    parameter int N_MUL   = 2,
    parameter int N_LD    = 2,
    parameter int N_ST    = 2,
    parameter int ADD_LAT = 2,
    parameter int MUL_LAT = 4,
    parameter int MEM_LAT = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   iss_valid,
    input  logic [1:0]             iss_op,
    input  logic [REG_W-1:0]       iss_dst,
    input  logic [REG_W-1:0]       iss_src1,
    input  logic [REG_W-1:0]       iss_src2,
    input  logic [ADDR_W-1:0]      iss_addr,
    output logic                   iss_ready,
    output logic [NREG*DATA_W-1:0] regs_flat,
    output logic                   quiet,
    output logic                   cdb_valid,
    output logic [TAG_W-1:0]       cdb_tag,
    output logic [DATA_W-1:0]      cdb_value
);
    localparam int ADD_BASE = 1;
    localparam int MUL_BASE = ADD_BASE + N_ADD;
    localparam int LD_BASE  = MUL_BASE + N_MUL;
    localparam int ST_BASE  = LD_BASE + N_LD;

    word_t rval  [NREG];
    tag_t  rstat [NREG];
    bus_t  bus;
    op_e   op;
    opnd_t s1, s2, fwd_raw, fwd_r;
    logic  fire, writes_dst, fwd_hit;
    logic  add_free, mul_free, ld_free, st_free;
    logic  add_req, mul_req, ld_req;
    logic  add_idle, mul_idle, ld_idle, st_idle;
    tag_t  add_ftag, mul_ftag, ld_ftag, st_ftag, dst_tag;
    tag_t  add_rtag, mul_rtag, ld_rtag;
    word_t add_rval, mul_rval, ld_rval, mem_rd;

    assign op = op_e'(iss_op);
    assign s1 = snoop(opnd_t'{rstat[iss_src1], rval[iss_src1]}, bus);
    assign s2 = snoop(opnd_t'{rstat[iss_src2], rval[iss_src2]}, bus);
    assign fwd_r = snoop(fwd_raw, bus);

    always_comb begin
        case (op)
            OP_ADD:  iss_ready = add_free;
            OP_MUL:  iss_ready = mul_free;
            OP_LOAD: iss_ready = fwd_hit || ld_free;
            default: iss_ready = st_free && !fwd_hit;
        endcase
        case (op)
            OP_ADD:  dst_tag = add_ftag;
            OP_MUL:  dst_tag = mul_ftag;
            default: dst_tag = fwd_hit ? fwd_r.q : ld_ftag;
        endcase
    end

    assign fire       = iss_valid && iss_ready;
    assign writes_dst = fire && (op != OP_STORE);

    // fixed-priority result bus: multiply, then add, then load
    always_comb begin
        bus.valid = mul_req || add_req || ld_req;
        if (mul_req)      begin bus.tag = mul_rtag; bus.value = mul_rval; end
        else if (add_req) begin bus.tag = add_rtag; bus.value = add_rval; end
        else if (ld_req)  begin bus.tag = ld_rtag;  bus.value = ld_rval;  end
        else              begin bus.tag = '0;       bus.value = '0;       end
    end
    assign cdb_valid = bus.valid;
    assign cdb_tag   = bus.tag;
    assign cdb_value = bus.value;

    tsb_rs_bank #(.N(N_ADD), .BASE(ADD_BASE), .LAT(ADD_LAT), .IS_MUL(1'b0)) u_add (
        .clk, .rst, .bus, .alloc(fire && op == OP_ADD), .a_in(s1), .b_in(s2),
        .has_free(add_free), .free_tag(add_ftag), .req(add_req), .req_tag(add_rtag),
        .req_val(add_rval), .grant(add_req && !mul_req), .idle(add_idle));

    tsb_rs_bank #(.N(N_MUL), .BASE(MUL_BASE), .LAT(MUL_LAT), .IS_MUL(1'b1)) u_mul (
        .clk, .rst, .bus, .alloc(fire && op == OP_MUL), .a_in(s1), .b_in(s2),
        .has_free(mul_free), .free_tag(mul_ftag), .req(mul_req), .req_tag(mul_rtag),
        .req_val(mul_rval), .grant(mul_req), .idle(mul_idle));

    tsb_ld_bank #(.N(N_LD), .BASE(LD_BASE), .LAT(MEM_LAT)) u_ld (
        .clk, .rst, .alloc(fire && op == OP_LOAD && !fwd_hit), .mem_data(mem_rd),
        .has_free(ld_free), .free_tag(ld_ftag), .req(ld_req), .req_tag(ld_rtag),
        .req_val(ld_rval), .grant(ld_req && !mul_req && !add_req), .idle(ld_idle));

    tsb_st_bank #(.N(N_ST), .BASE(ST_BASE), .AW(ADDR_W)) u_st (
        .clk, .rst, .bus, .alloc(fire && op == OP_STORE), .st_addr(iss_addr), .d_in(s1),
        .has_free(st_free), .free_tag(st_ftag), .lk_addr(iss_addr), .fwd_hit,
        .fwd(fwd_raw), .rd_data(mem_rd), .idle(st_idle));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++) begin
                rval[r]  <= word_t'(r + 1);
                rstat[r] <= '0;
            end
        end else begin
            for (int r = 0; r < NREG; r++) begin
                if (rstat[r] != '0 && bus.valid && bus.tag == rstat[r]) begin
                    rval[r]  <= bus.value;
                    rstat[r] <= '0;
                end
            end
            if (writes_dst) begin
                rstat[iss_dst] <= dst_tag;
                if (op == OP_LOAD && fwd_hit && fwd_r.q == '0) rval[iss_dst] <= fwd_r.v;
            end
        end
    end

    always_comb begin
        quiet = add_idle && mul_idle && ld_idle && st_idle;
        for (int r = 0; r < NREG; r++) begin
            regs_flat[r*DATA_W +: DATA_W] = rval[r];
            if (rstat[r] != '0) quiet = 1'b0;
        end
    end

    // R3: the bus never carries the "ready" tag
    assert_tag_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        cdb_valid |-> (cdb_tag != '0));
    // R4: a pending multiply result owns the bus
    assert_priority_R4: assert property (@(posedge clk) disable iff (rst)
        mul_req |-> (cdb_valid && cdb_tag == mul_rtag));
    // R6: status clears only for its own tag, and a newer rename survives
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        assert_status_clear_R6: assert property (@(posedge clk) disable iff (rst)
            (cdb_valid && rstat[g] == cdb_tag && rstat[g] != '0
             && !(writes_dst && iss_dst == REG_W'(g)))
            |=> (rstat[g] == '0 && rval[g] == $past(cdb_value)));
        assert_status_keep_R6: assert property (@(posedge clk) disable iff (rst)
            (rstat[g] != '0 && !(cdb_valid && cdb_tag == rstat[g])
             && !(writes_dst && iss_dst == REG_W'(g)))
            |=> $stable(rstat[g]));
    end
endmodule

// File: tb/sim_tsb_core.sv
`timescale 1ns/1ps
module sim_tsb_core;
    localparam int ADD_LAT = 2;
    localparam int MUL_LAT = 4;
    localparam int MEM_LAT = 12;
    // program vectors: {op[1:0], dst[1:0], src1[1:0], src2[1:0], addr[3:0]}
    localparam logic [11:0] PROG [14] = '{
        {2'd1, 2'd0, 2'd1, 2'd2, 4'd0},
        {2'd0, 2'd3, 2'd0, 2'd1, 4'd0},
        {2'd3, 2'd0, 2'd3, 2'd0, 4'd3},
        {2'd2, 2'd1, 2'd0, 2'd0, 4'd3},
        {2'd0, 2'd2, 2'd1, 2'd3, 4'd0},
        {2'd2, 2'd0, 2'd0, 2'd0, 4'd9},
        {2'd1, 2'd3, 2'd0, 2'd2, 4'd0},
        {2'd0, 2'd0, 2'd3, 2'd3, 4'd0},
        {2'd3, 2'd0, 2'd0, 2'd0, 4'd9},
        {2'd2, 2'd2, 2'd0, 2'd0, 4'd9},
        {2'd0, 2'd1, 2'd2, 2'd1, 4'd0},
        {2'd0, 2'd1, 2'd1, 2'd1, 4'd0},
        {2'd3, 2'd0, 2'd1, 2'd0, 4'd3},
        {2'd2, 2'd2, 2'd0, 2'd0, 4'd4}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iss_valid = 1'b0;
    logic [1:0]  iss_op = '0, iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic [3:0]  iss_addr = '0;
    logic        iss_ready, quiet, cdb_valid;
    logic [127:0] regs_flat;
    logic [3:0]  cdb_tag;
    logic [31:0] cdb_value;

    int checks = 0, errors = 0, ld_seen = 0;
    bit done = 0;
    logic [31:0] rr [4];
    logic [31:0] rm [16];

    always #4 clk = ~clk;

    tsb_core #(.ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT), .MEM_LAT(MEM_LAT)) u0 (
        .clk, .rst, .iss_valid, .iss_op, .iss_dst, .iss_src1, .iss_src2, .iss_addr,
        .iss_ready, .regs_flat, .quiet, .cdb_valid, .cdb_tag, .cdb_value);

    always @(negedge clk) if (cdb_valid && (cdb_tag == 4'd5 || cdb_tag == 4'd6)) ld_seen++;

    function automatic logic [31:0] reg_of(input int r);
        return regs_flat[r*32 +: 32];
    endfunction

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [1:0] d, input logic [1:0] a,
                         input logic [1:0] b, input logic [3:0] ad);
        @(negedge clk);
        iss_op = op; iss_dst = d; iss_src1 = a; iss_src2 = b; iss_addr = ad;
        iss_valid = 1'b1;
        #1;
        while (!iss_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        iss_valid = 1'b0;
        case (op)
            2'd0: rr[d] = rr[a] + rr[b];
            2'd1: rr[d] = rr[a] * rr[b];
            2'd2: rr[d] = rm[ad];
            default: rm[ad] = rr[a];
        endcase
    endtask

    task automatic wait_quiet(input string rq);
        int n = 0;
        @(negedge clk);
        while (!quiet && n < 500) begin
            @(negedge clk);
            n++;
        end
        check(quiet, rq, n, 0);
    endtask

    task automatic cmp_regs(input string rq);
        for (int r = 0; r < 4; r++) check(reg_of(r) == rr[r], rq, reg_of(r), rr[r]);
    endtask

    initial begin
        for (int r = 0; r < 4; r++) rr[r] = 32'(r + 1);
        for (int a = 0; a < 16; a++) rm[a] = 32'(100 + a);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        cmp_regs("R1 reset regs");
        check(quiet == 1'b1, "R1 quiet", quiet, 1);
        check(iss_ready == 1'b1, "R1 ready", iss_ready, 1);

        // R2 R5 R10 vector program against in-order model
        for (int i = 0; i < 14; i++) begin
            logic [11:0] v = PROG[i];
            issue(v[11:10], v[9:8], v[7:6], v[5:4], v[3:0]);
        end
        wait_quiet("R2 drain");
        cmp_regs("R2 program regs");
        issue(2'd2, 2'd0, 2'd0, 2'd0, 4'd3);
        issue(2'd2, 2'd1, 2'd0, 2'd0, 4'd9);
        wait_quiet("R2 drain");
        cmp_regs("R2 stored words");

        // R11 memory latency, R1 memory reset value, R3 load tag
        issue(2'd2, 2'd0, 2'd0, 2'd0, 4'd5);
        repeat (MEM_LAT - 1) @(posedge clk);
        @(negedge clk);
        check(!cdb_valid, "R11 early", cdb_valid, 0);
        @(posedge clk); @(negedge clk);
        check(cdb_valid && cdb_tag == 4'd5, "R11 load tag", cdb_tag, 5);
        check(cdb_value == 32'd105, "R1 R11 mem value", cdb_value, 105);
        wait_quiet("R11 drain");

        // R9 add latency
        issue(2'd0, 2'd1, 2'd2, 2'd3, 4'd0);
        repeat (ADD_LAT - 1) @(posedge clk);
        @(negedge clk);
        check(!cdb_valid, "R9 early", cdb_valid, 0);
        @(posedge clk); @(negedge clk);
        check(cdb_valid && cdb_tag == 4'd1, "R9 R3 add tag", cdb_tag, 1);
        check(cdb_value == rr[1], "R9 add value", cdb_value, rr[1]);
        wait_quiet("R9 drain");

        // R4 multiply beats add in the same cycle
        issue(2'd1, 2'd0, 2'd1, 2'd2, 4'd0);
        @(posedge clk);
        issue(2'd0, 2'd3, 2'd1, 2'd2, 4'd0);
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(cdb_valid && cdb_tag == 4'd3, "R4 mul first", cdb_tag, 3);
        @(posedge clk); @(negedge clk);
        check(cdb_valid && cdb_tag == 4'd1 && cdb_value == rr[3], "R4 add held", cdb_tag, 1);
        wait_quiet("R4 drain");

        // R4 add beats load in the same cycle
        issue(2'd2, 2'd2, 2'd0, 2'd0, 4'd6);
        repeat (MEM_LAT - 3) @(posedge clk);
        issue(2'd0, 2'd1, 2'd0, 2'd3, 4'd0);
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(cdb_valid && cdb_tag == 4'd1, "R4 add before load", cdb_tag, 1);
        @(posedge clk); @(negedge clk);
        check(cdb_valid && cdb_tag == 4'd5 && cdb_value == 32'd106, "R4 load held", cdb_tag, 5);
        wait_quiet("R4 drain");
        cmp_regs("R4 regs");

        // R7 issue during broadcast of its source; R5 both operands share a tag
        issue(2'd0, 2'd0, 2'd1, 2'd2, 4'd0);
        @(posedge clk); @(posedge clk);
        issue(2'd0, 2'd3, 2'd0, 2'd0, 4'd0);
        wait_quiet("R7 drain");
        check(reg_of(3) == rr[3], "R7 R5 bypass", reg_of(3), rr[3]);

        // R6 slow older producer must not overwrite newer rename
        issue(2'd1, 2'd0, 2'd1, 2'd2, 4'd0);
        issue(2'd0, 2'd0, 2'd2, 2'd3, 4'd0);
        issue(2'd0, 2'd1, 2'd0, 2'd0, 4'd0);
        wait_quiet("R6 drain");
        check(reg_of(0) == rr[0], "R6 newest kept", reg_of(0), rr[0]);
        check(reg_of(1) == rr[1], "R6 consumer", reg_of(1), rr[1]);

        // R8 add pool full, multiply still accepted; R5 two waiters on one load
        issue(2'd2, 2'd0, 2'd0, 2'd0, 4'd7);
        issue(2'd0, 2'd1, 2'd0, 2'd0, 4'd0);
        issue(2'd0, 2'd2, 2'd0, 2'd0, 4'd0);
        @(negedge clk);
        iss_op = 2'd0; iss_dst = 2'd3; iss_src1 = 2'd0; iss_src2 = 2'd1; iss_valid = 1'b1;
        #1 check(!iss_ready, "R8 add stall", iss_ready, 0);
        iss_op = 2'd1;
        #1 check(iss_ready, "R8 mul free", iss_ready, 1);
        iss_valid = 1'b0;
        issue(2'd0, 2'd3, 2'd0, 2'd1, 4'd0);
        wait_quiet("R8 drain");
        cmp_regs("R8 R5 regs");

        // R12 second store to same address; R10 forwarded load
        ld_seen = 0;
        issue(2'd1, 2'd0, 2'd1, 2'd2, 4'd0);
        issue(2'd3, 2'd0, 2'd0, 2'd0, 4'd8);
        @(negedge clk);
        iss_op = 2'd3; iss_src1 = 2'd3; iss_addr = 4'd8; iss_valid = 1'b1;
        #1 check(!iss_ready, "R12 store stall", iss_ready, 0);
        iss_op = 2'd2;
        #1 check(iss_ready, "R10 forward ready", iss_ready, 1);
        iss_valid = 1'b0;
        issue(2'd2, 2'd3, 2'd0, 2'd0, 4'd8);
        wait_quiet("R10 drain");
        check(reg_of(3) == rr[3], "R10 forwarded value", reg_of(3), rr[3]);
        check(ld_seen == 0, "R10 no load tag", ld_seen, 0);
        issue(2'd2, 2'd2, 2'd0, 2'd0, 4'd8);
        wait_quiet("R10 drain");
        check(reg_of(2) == rr[2], "R10 R12 stored word", reg_of(2), rr[2]);
        check(ld_seen == 1, "R11 memory load tag", ld_seen, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule